// File: doc/BRIEF.md
# Two-Way Latched Bus Transceiver

This block passes data between two parallel buses, A and B, in both directions at once. The A-to-B path and the B-to-A path are independent channels. Each has its own storage element and four controls: an active-low output enable, an active-low clock enable, an active-high latch enable and a direction clock.

The storage element works in one of three ways. While the latch enable is high it is transparent and the input appears at the output in the same cycle. While the latch enable is low it holds its value, unless a rising edge of the direction clock arrives with the clock enable low; that edge captures the input. A high clock enable blocks capture.

The A side output is an 18-bit value with one drive-enable flag. The B side is open drain: each bit only pulls low, and an undriven bit is left to external termination. Everything runs on one system clock. Each direction clock is sampled on that clock to find its rising edges.

Top module: `duplex_latch_xcvr`

## Requirements
- R1: While `rst_n` is low, `a_drive` is 0 and `b_pull_low` is all zeros. The synchronous reset clears both stored values to zero.
- R2: `a_drive` is 1 exactly when `rst_n` is high and `ba_oe_n` is low. While it is 1, `a_out` carries the B-to-A path value.
- R3: `b_pull_low[i]` is 1 only when `rst_n` is high, `ab_oe_n` is low and bit i of the A-to-B path value is 0. While `ab_oe_n` is high every bit is 0.
- R4: While a direction's latch enable is high, its path value equals its input bus in the same cycle. The input bus is `a_in` for A-to-B and `b_in` for B-to-A.
- R5: A direction clock counts as rising at a system clock edge when it is sampled high there and was sampled low at the previous edge. If that happens with the latch enable low and the clock enable low, the input sampled at that edge is stored and becomes the path value from the next cycle on.
- R6: While the clock enable is high, rising edges of the direction clock do not change the stored value.
- R7: When the latch enable falls, the path value stays at the input seen in the last cycle the latch enable was high. It then holds until a qualifying capture happens.
- R8: The two directions are fully independent. B-to-A controls and `b_in` never affect `b_pull_low`, and A-to-B controls and `a_in` never affect `a_out`.
- R9: A direction clock that stays high captures only once. A clock that is already high when reset is released does not count as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_in | input | 18 | A bus input data |
| a_out | output | 18 | A bus output value |
| a_drive | output | 1 | A bus output drive enable |
| b_in | input | 18 | B bus input data |
| b_pull_low | output | 18 | Per-bit open-drain pull-low enable on B |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_ce_n | input | 1 | A-to-B clock enable, active low |
| ab_le | input | 1 | A-to-B latch enable, transparent when high |
| ab_clk | input | 1 | A-to-B capture clock |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_ce_n | input | 1 | B-to-A clock enable, active low |
| ba_le | input | 1 | B-to-A latch enable, transparent when high |
| ba_clk | input | 1 | B-to-A capture clock |

## Verification
The bench targets the moment the latch closes. A design that stored the input one cycle late, or the input from after the fall, would hold the wrong word. It also holds a direction clock high for several cycles and across reset release. An edge detector that compared against the wrong history would capture again or capture spuriously. The clock enable is toggled while the direction clock keeps pulsing, to catch captures that leak through the inhibit. A long pseudo-random sweep drives both directions at once. Any cross-coupling of controls between the two paths, or an inverted open-drain polarity, then shows up as a mismatch against the bench's cycle model.

// File: rtl/duplex_latch_xcvr.sv
module duplex_latch_xcvr #(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_drive,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_pull_low,
  input  logic             ab_oe_n,
  input  logic             ab_ce_n,
  input  logic             ab_le,
  input  logic             ab_clk,
  input  logic             ba_oe_n,
  input  logic             ba_ce_n,
  input  logic             ba_le,
  input  logic             ba_clk
);

  logic [WIDTH-1:0] ab_q, ba_q;
  logic             ab_clk_q, ba_clk_q;
  logic             ab_rise, ba_rise;
  logic [WIDTH-1:0] ab_val, ba_val;

  assign ab_rise = ab_clk & ~ab_clk_q;
  assign ba_rise = ba_clk & ~ba_clk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ab_q     <= '0;
      ab_clk_q <= 1'b1;
    end else begin
      ab_clk_q <= ab_clk;
      if (ab_le || (ab_rise && !ab_ce_n))
        ab_q <= a_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ba_q     <= '0;
      ba_clk_q <= 1'b1;
    end else begin
      ba_clk_q <= ba_clk;
      if (ba_le || (ba_rise && !ba_ce_n))
        ba_q <= b_in;
    end
  end

  assign ab_val     = ab_le ? a_in : ab_q;
  assign ba_val     = ba_le ? b_in : ba_q;

  assign a_drive    = rst_n & ~ba_oe_n;
  assign a_out      = ba_val;
  assign b_pull_low = {WIDTH{rst_n & ~ab_oe_n}} & ~ab_val;

endmodule

module duplex_latch_xcvr_chk #(
  parameter int WIDTH = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] a_out,
  input logic             a_drive,
  input logic [WIDTH-1:0] b_in,
  input logic [WIDTH-1:0] b_pull_low,
  input logic             ab_oe_n,
  input logic             ab_ce_n,
  input logic             ab_le,
  input logic             ab_clk,
  input logic             ba_oe_n,
  input logic             ba_le
);

  logic ab_clk_seen;
  always_ff @(posedge clk) begin
    if (!rst_n) ab_clk_seen <= 1'b1;
    else        ab_clk_seen <= ab_clk;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (!a_drive && b_pull_low == '0));

  assert_a_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ba_oe_n |-> !a_drive);

  assert_open_drain_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ab_oe_n |-> b_pull_low == '0);

  assert_transparent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_oe_n && ab_le) |-> b_pull_low == ~a_in);

  assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_oe_n && !ab_le && $past(rst_n && ab_clk && !ab_clk_seen && !ab_ce_n && !ab_le))
      |-> b_pull_low == ~$past(a_in));

  assert_inhibit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_oe_n && !ab_le && $past(rst_n && !ab_oe_n && !ab_le && ab_ce_n))
      |-> $stable(b_pull_low));

  assert_b_to_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ba_oe_n && ba_le) |-> (a_drive && a_out == b_in));

endmodule

bind duplex_latch_xcvr duplex_latch_xcvr_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
  .b_in(b_in), .b_pull_low(b_pull_low), .ab_oe_n(ab_oe_n), .ab_ce_n(ab_ce_n),
  .ab_le(ab_le), .ab_clk(ab_clk), .ba_oe_n(ba_oe_n), .ba_le(ba_le)
);

// File: tb/test_duplex_latch_xcvr.sv
module test_duplex_latch_xcvr;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_pull_low;
  logic a_drive;
  logic ab_oe_n = 1'b1, ab_ce_n = 1'b1, ab_le = 1'b0, ab_clk = 1'b0;
  logic ba_oe_n = 1'b1, ba_ce_n = 1'b1, ba_le = 1'b0, ba_clk = 1'b0;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [W-1:0] m_ab, m_ba;
  logic m_abc, m_bac;

  always #2 clk = ~clk;

  duplex_latch_xcvr #(.WIDTH(W)) i_duplex_latch_xcvr (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
    .b_in(b_in), .b_pull_low(b_pull_low),
    .ab_oe_n(ab_oe_n), .ab_ce_n(ab_ce_n), .ab_le(ab_le), .ab_clk(ab_clk),
    .ba_oe_n(ba_oe_n), .ba_ce_n(ba_ce_n), .ba_le(ba_le), .ba_clk(ba_clk));

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic string ab_tag();
    if (!rst_n)        return "R1";
    if (ab_oe_n)       return "R3";
    if (ab_le)         return "R4";
    if (ab_ce_n)       return "R6";
    return "R7/R5";
  endfunction

  task automatic compare_model();
    logic [W-1:0] abv, bav;
    abv = ab_le ? a_in : m_ab;
    bav = ba_le ? b_in : m_ba;
    chk(ab_tag(), b_pull_low, (rst_n && !ab_oe_n) ? ~abv : '0);
    chk(rst_n ? "R2" : "R1", {{(W-1){1'b0}}, a_drive}, {{(W-1){1'b0}}, rst_n & ~ba_oe_n});
    if (a_drive) chk("R8", a_out, bav);
  endtask

  task automatic model_edge();
    if (!rst_n) begin
      m_ab = '0; m_ba = '0; m_abc = 1'b1; m_bac = 1'b1;
    end else begin
      if (ab_le || (ab_clk && !m_abc && !ab_ce_n)) m_ab = a_in;
      if (ba_le || (ba_clk && !m_bac && !ba_ce_n)) m_ba = b_in;
      m_abc = ab_clk; m_bac = ba_clk;
    end
  endtask

  task automatic tick();
    #1 compare_model();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    m_ab = '0; m_ba = '0; m_abc = 1'b1; m_bac = 1'b1;
    @(negedge clk);
    ab_oe_n = 1'b0; ba_oe_n = 1'b0; ab_clk = 1'b1;
    tick(); tick();
    chk("R1", b_pull_low, '0);
    rst_n = 1'b1; a_in = 18'h2AAAA;
    // R1 storage cleared: path shows zero so every bit pulls low
    #1 chk("R1", b_pull_low, 18'h3FFFF);
    chk("R1", {{(W-1){1'b0}}, a_drive}, 18'h1);
    chk("R1", a_out, '0);
    tick();
    // R9 clock high at reset release: no capture, still zero
    ab_ce_n = 1'b0; tick(); tick();
    #1 chk("R9", b_pull_low, 18'h3FFFF);
    // R5 rising edge capture, visible next cycle
    ab_clk = 1'b0; tick();
    ab_clk = 1'b1; tick();
    a_in = 18'h00F0F;
    #1 chk("R5", b_pull_low, ~18'h2AAAA);
    // R9 held high: no second capture
    tick(); tick();
    #1 chk("R9", b_pull_low, ~18'h2AAAA);
    // R6 inhibited edge
    ab_ce_n = 1'b1; ab_clk = 1'b0; tick(); ab_clk = 1'b1; tick(); tick();
    #1 chk("R6", b_pull_low, ~18'h2AAAA);
    // R4 transparent, then R7 latch close keeps last seen word
    ab_le = 1'b1; a_in = 18'h12345;
    #1 chk("R4", b_pull_low, ~18'h12345);
    tick();
    a_in = 18'h3C3C3; tick();
    ab_le = 1'b0; a_in = 18'h00001;
    #1 chk("R7", b_pull_low, ~18'h3C3C3);
    tick(); tick();
    #1 chk("R7", b_pull_low, ~18'h3C3C3);
    // R3 disable releases all bits
    ab_oe_n = 1'b1;
    #1 chk("R3", b_pull_low, '0);
    // R8 B-to-A toggled, A-to-B output frozen
    ab_oe_n = 1'b0; ba_le = 1'b1; ba_ce_n = 1'b0;
    for (int k = 0; k < 6; k++) begin
      b_in = 18'(k * 18'h0A5A5); ba_clk = k[0]; tick();
      #1 chk("R8", b_pull_low, ~18'h3C3C3);
      chk("R8", a_out, b_in);
    end
    // Sweep both directions against the cycle model
    for (int n = 0; n < 20000; n++) begin
      logic [31:0] r;
      r = $urandom;
      a_in    = 18'($urandom);
      b_in    = 18'($urandom);
      ab_oe_n = (r[2:0] == 0);
      ba_oe_n = (r[5:3] == 0);
      ab_ce_n = r[6] & r[7];
      ba_ce_n = r[8] & r[9];
      ab_le   = (r[12:10] == 0);
      ba_le   = (r[15:13] == 0);
      ab_clk  = r[16];
      ba_clk  = r[17];
      rst_n   = (r[27:20] != 0);
      tick();
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule